// File: doc/BRIEF.md
# Unchannelized Serial Octet Aligner

This block sits on one 2.048 Mb/s serial link that carries a plain bit stream with no time-slot structure. In the receive direction it collects the incoming bits into octets. An external alignment pulse marks where octets start: the bit that arrives together with the pulse becomes the most significant bit of a new octet. Between pulses the aligner keeps counting by itself and delivers one octet every eight clocks with a one-cycle valid strobe. If a pulse arrives anywhere other than an octet boundary, the counter restarts at that pulse and a sticky flag records the realignment.

In the transmit direction the block reads one octet every eight clocks and shifts it out MSB first. It marks the MSB of every 32nd octet with its own alignment pulse. A transmit-side pulse restarts both the octet and the frame counting.

One select input chooses the timing source for both directions. With the select low, the block uses the shared clocks and shared pulses. With the select high, it uses the clocks and pulses that belong to this link. The select is meant to change only while reset is held.

Top module: `serial_octet_aligner`

## Requirements
- R1: The receive bit sampled together with the selected receive pulse is bit 7 of an octet. The following bits fill bits 6 down to 0. On the clock edge that samples the eighth bit, `rx_octet` takes the assembled value and `rx_valid` goes high for exactly one cycle.
- R2: Without further pulses, the receiver delivers one octet on every eighth clock after lock. `rx_valid` is never high in two consecutive cycles.
- R3: `rx_valid` stays low from reset until the first selected receive pulse has been sampled.
- R4: A selected receive pulse that falls exactly on an octet boundary after lock (every 256 clocks in normal use) leaves `rx_realign` low and does not disturb the octet stream.
- R5: A selected receive pulse that falls off an octet boundary after lock discards the partial octet. No `rx_valid` is issued for that partial octet, including when the pulse lands on the bit where that octet would have completed. The pulse starts a new octet and sets `rx_realign`, which stays high until reset.
- R6: With `clk_sel` = 0, the shared clocks and shared pulses drive the block and the per-link pulses have no effect. With `clk_sel` = 1, the per-link clocks and per-link pulses drive the block and the shared pulses have no effect.
- R7: `tx_take` is high in the cycle whose rising edge captures `tx_octet`, once every eight clocks. Starting with that edge, `tx_bit` carries bits 7 down to 0 of the captured octet, one bit per clock.
- R8: `tx_frame` is high in the cycle that carries the MSB of octet 0, 32, 64 and so on. Counting starts at the first octet after reset or after a transmit pulse. `tx_frame` is low in every other cycle.
- R9: A selected transmit pulse forces `tx_take` high in its own cycle and restarts the octet there, even in the middle of an octet. The MSB of that octet carries `tx_frame`.
- R10: While reset is held and right after it is released, `rx_valid`, `rx_realign`, `tx_bit` and `tx_frame` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 1 | 0: shared clocks and pulses, 1: per-link clocks and pulses |
| com_tx_clk | input | 1 | Shared transmit clock |
| com_rx_clk | input | 1 | Shared receive clock |
| lnk_tx_clk | input | 1 | Per-link transmit clock |
| lnk_rx_clk | input | 1 | Per-link receive clock |
| com_tx_sync | input | 1 | Shared transmit alignment pulse |
| com_rx_sync | input | 1 | Shared receive alignment pulse |
| lnk_tx_sync | input | 1 | Per-link transmit alignment pulse |
| lnk_rx_sync | input | 1 | Per-link receive alignment pulse |
| rx_bit | input | 1 | Serial receive data |
| rx_octet | output | OCTET_W | Last assembled receive octet |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_octet` |
| rx_realign | output | 1 | Sticky flag: an off-boundary pulse was seen |
| tx_octet | input | OCTET_W | Octet offered for transmission |
| tx_take | output | 1 | `tx_octet` is captured at the coming edge |
| tx_bit | output | 1 | Serial transmit data |
| tx_frame | output | 1 | Generated transmit alignment pulse |

## Verification
Two receive functions can fall in the same cycle: completing an octet and restarting on a pulse. The bench provokes this by locking the receiver and then raising the pulse on exactly the bit where the running octet would have finished. It judges the result by checking three things: no strobe is issued in that cycle, the realignment flag rises, and the next eight bits come out as a correct octet. The transmit side has a matching collision, a transmit pulse in the middle of an octet. The bench checks that the capture strobe and the frame mark move to that cycle.

// File: rtl/serial_octet_aligner.sv
module serial_octet_aligner #(
  parameter int OCTET_W      = 8,
  parameter int FRAME_OCTETS = 32
) (
  input  logic               rst_n,
  input  logic               clk_sel,
  input  logic               com_tx_clk,
  input  logic               com_rx_clk,
  input  logic               lnk_tx_clk,
  input  logic               lnk_rx_clk,
  input  logic               com_tx_sync,
  input  logic               com_rx_sync,
  input  logic               lnk_tx_sync,
  input  logic               lnk_rx_sync,
  input  logic               rx_bit,
  output logic [OCTET_W-1:0] rx_octet,
  output logic               rx_valid,
  output logic               rx_realign,
  input  logic [OCTET_W-1:0] tx_octet,
  output logic               tx_take,
  output logic               tx_bit,
  output logic               tx_frame
);
  localparam int CNT_W = $clog2(OCTET_W);
  localparam int FRM_W = $clog2(FRAME_OCTETS);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OCTET_W - 1);
  localparam logic [FRM_W-1:0] OCT_LAST = FRM_W'(FRAME_OCTETS - 1);

  logic rclk, rsync, tclk, tsync;
  assign rclk  = clk_sel ? lnk_rx_clk  : com_rx_clk;
  assign rsync = clk_sel ? lnk_rx_sync : com_rx_sync;
  assign tclk  = clk_sel ? lnk_tx_clk  : com_tx_clk;
  assign tsync = clk_sel ? lnk_tx_sync : com_tx_sync;

  // receive
  logic [CNT_W-1:0]   rcnt;
  logic               rlock;
  logic [OCTET_W-1:0] rsh;
  logic [CNT_W-1:0]   rpos;
  logic [OCTET_W-1:0] rsh_nx;
  logic               rlast;

  assign rpos   = rsync ? '0 : rcnt;
  assign rsh_nx = {rsh[OCTET_W-2:0], rx_bit};
  assign rlast  = (rpos == BIT_LAST);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt       <= '0;
      rlock      <= 1'b0;
      rsh        <= '0;
      rx_octet   <= '0;
      rx_valid   <= 1'b0;
      rx_realign <= 1'b0;
    end else begin
      rcnt     <= rlast ? '0 : rpos + 1'b1;
      rsh      <= rsh_nx;
      rx_valid <= rlast && (rlock || rsync);
      if (rlast) rx_octet <= rsh_nx;
      if (rsync) rlock <= 1'b1;
      if (rsync && rlock && rcnt != '0) rx_realign <= 1'b1;
    end
  end

  // transmit
  logic [CNT_W-1:0]   tcnt;
  logic [FRM_W-1:0]   ocnt;
  logic [OCTET_W-1:0] tsh;
  logic [CNT_W-1:0]   tpos;
  logic [FRM_W-1:0]   oidx;

  assign tpos    = tsync ? '0 : tcnt;
  assign oidx    = tsync ? '0 : ocnt;
  assign tx_take = (tpos == '0);

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt     <= '0;
      ocnt     <= '0;
      tsh      <= '0;
      tx_bit   <= 1'b0;
      tx_frame <= 1'b0;
    end else begin
      tcnt <= (tpos == BIT_LAST) ? '0 : tpos + 1'b1;
      if (tx_take) begin
        tsh      <= tx_octet << 1;
        tx_bit   <= tx_octet[OCTET_W-1];
        tx_frame <= (oidx == '0);
        ocnt     <= (oidx == OCT_LAST) ? '0 : oidx + 1'b1;
      end else begin
        tsh      <= tsh << 1;
        tx_bit   <= tsh[OCTET_W-1];
        tx_frame <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_octet_aligner_chk.sv
module serial_octet_aligner_chk (
  input logic rst_n,
  input logic rclk,
  input logic tclk,
  input logic rsync,
  input logic rx_valid,
  input logic rx_realign,
  input logic tx_take,
  input logic tx_frame
);
  logic seen;
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (rsync) seen <= 1'b1;
  end

  assert_no_valid_before_lock_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    !seen |-> !rx_valid);
  assert_valid_single_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_realign_sticky_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rx_realign |=> rx_realign);
  assert_frame_after_take_R8: assert property (@(posedge tclk) disable iff (!rst_n)
    tx_frame |-> $past(tx_take));
  assert_frame_single_R8: assert property (@(posedge tclk) disable iff (!rst_n)
    tx_frame |=> !tx_frame);
  assert_take_spacing_R7: assert property (@(posedge tclk) disable iff (!rst_n)
    $rose(tx_frame) |-> !tx_take || $past(tx_take));
endmodule

bind serial_octet_aligner serial_octet_aligner_chk u_chk (
  .rst_n(rst_n), .rclk(rclk), .tclk(tclk), .rsync(rsync),
  .rx_valid(rx_valid), .rx_realign(rx_realign),
  .tx_take(tx_take), .tx_frame(tx_frame)
);

// File: tb/sim_serial_octet_aligner.sv
`timescale 1ns/1ps
module sim_serial_octet_aligner;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic bsel = 1'b0;
  logic rst_n;
  logic com_tx_sync, com_rx_sync, lnk_tx_sync, lnk_rx_sync, rx_bit;
  logic [7:0] tx_octet, rx_octet;
  logic rx_valid, rx_realign, tx_take, tx_bit, tx_frame;
  logic com_clk, lnk_clk;
  assign com_clk = bsel ? 1'b0 : clk;
  assign lnk_clk = bsel ? clk : 1'b0;

  serial_octet_aligner u0 (
    .rst_n(rst_n), .clk_sel(bsel),
    .com_tx_clk(com_clk), .com_rx_clk(com_clk),
    .lnk_tx_clk(lnk_clk), .lnk_rx_clk(lnk_clk),
    .com_tx_sync(com_tx_sync), .com_rx_sync(com_rx_sync),
    .lnk_tx_sync(lnk_tx_sync), .lnk_rx_sync(lnk_rx_sync),
    .rx_bit(rx_bit), .rx_octet(rx_octet), .rx_valid(rx_valid),
    .rx_realign(rx_realign), .tx_octet(tx_octet), .tx_take(tx_take),
    .tx_bit(tx_bit), .tx_frame(tx_frame)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0; bsel = sel;
    com_tx_sync = 0; com_rx_sync = 0; lnk_tx_sync = 0; lnk_rx_sync = 0;
    rx_bit = 0; tx_octet = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one clock: drive inputs now, return at next negedge
  task automatic step(input logic b, input logic rs, input logic rnoise,
                      input logic ts, input logic tnoise);
    rx_bit      = b;
    com_rx_sync = bsel ? rnoise : rs;
    lnk_rx_sync = bsel ? rs : rnoise;
    com_tx_sync = bsel ? tnoise : ts;
    lnk_tx_sync = bsel ? ts : tnoise;
    @(negedge clk);
    com_rx_sync = 0; lnk_rx_sync = 0; com_tx_sync = 0; lnk_tx_sync = 0;
  endtask

  // noise: bit index at which the unselected receive pulse fires (8 = none)
  task automatic rx_send(input logic [7:0] v, input logic sync, input int noise,
                         input logic exp_valid, input string tag);
    logic [7:0] vals = '0;
    for (int i = 0; i < 8; i++) begin
      step(v[7-i], sync && i == 0, i == noise, 1'b0, 1'b0);
      vals = {vals[6:0], rx_valid};
    end
    chk(tag, {24'd0, vals}, exp_valid ? 32'h01 : 32'h00);
    if (exp_valid) chk(tag, {24'd0, rx_octet}, {24'd0, v});
  endtask

  task automatic tx_send(input logic [7:0] v, input logic sync, input int noise,
                         input logic exp_frame, input string tag);
    logic [7:0] bits = '0, frm = '0, tk = '0;
    tx_octet = v;
    for (int i = 0; i < 8; i++) begin
      if (sync && i == 0) begin
        if (bsel) lnk_tx_sync = 1'b1; else com_tx_sync = 1'b1;
      end
      #1;
      tk = {tk[6:0], tx_take};
      step(1'b0, 1'b0, 1'b0, sync && i == 0, i == noise);
      bits = {bits[6:0], tx_bit};
      frm  = {frm[6:0], tx_frame};
    end
    chk({tag, " bits"}, {24'd0, bits}, {24'd0, v});
    chk({tag, " take"}, {24'd0, tk}, 32'h80);
    chk({tag, " frame"}, {24'd0, frm}, exp_frame ? 32'h80 : 32'h00);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R10 rx_valid", {31'd0, rx_valid}, 0);
    chk("R10 rx_realign", {31'd0, rx_realign}, 0);
    chk("R10 tx_bit", {31'd0, tx_bit}, 0);
    chk("R10 tx_frame", {31'd0, tx_frame}, 0);
  endtask

  task automatic t_prelock();
    int seen = 0;
    do_reset(1'b0);
    for (int i = 0; i < 29; i++) begin
      step(1'(i * 7 % 3 == 1), 1'b0, 1'b0, 1'b0, 1'b0);
      seen += int'(rx_valid);
    end
    chk("R3 no valid before pulse", seen, 0);
    rx_send(8'hA5, 1'b1, 8, 1'b1, "R1 first octet after pulse");
  endtask

  task automatic t_freerun();
    do_reset(1'b0);
    for (int k = 0; k < 33; k++)
      rx_send(8'(k * 37 + 5), k == 0 || k == 32, 8, 1'b1, "R2 free-run octet");
    chk("R4 boundary pulse no realign", {31'd0, rx_realign}, 0);
    rx_send(8'h3C, 1'b0, 8, 1'b1, "R4 stream continues");
  endtask

  task automatic t_misalign();
    do_reset(1'b0);
    rx_send(8'h5A, 1'b1, 8, 1'b1, "R5 lock");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 before off pulse", {31'd0, rx_realign}, 0);
    rx_send(8'hC3, 1'b1, 8, 1'b1, "R5 octet after off pulse");
    chk("R5 realign set", {31'd0, rx_realign}, 1);
    rx_send(8'h81, 1'b0, 8, 1'b1, "R5 after realign");
    chk("R5 realign sticky", {31'd0, rx_realign}, 1);
    // pulse on the bit that would complete the octet
    do_reset(1'b0);
    rx_send(8'h11, 1'b1, 8, 1'b1, "R5 relock");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_send(8'h96, 1'b1, 8, 1'b1, "R5 collide: no strobe on cut octet");
    chk("R5 collide realign", {31'd0, rx_realign}, 1);
  endtask

  task automatic t_select();
    do_reset(1'b1);
    rx_send(8'hE7, 1'b1, 8, 1'b1, "R6 link lock");
    rx_send(8'h42, 1'b0, 3, 1'b1, "R6 shared pulse ignored (sel 1)");
    rx_send(8'h99, 1'b0, 6, 1'b1, "R6 shared pulse ignored (sel 1)");
    chk("R6 realign sel 1", {31'd0, rx_realign}, 0);
    do_reset(1'b0);
    rx_send(8'h24, 1'b1, 8, 1'b1, "R6 shared lock");
    rx_send(8'h6B, 1'b0, 2, 1'b1, "R6 link pulse ignored (sel 0)");
    chk("R6 realign sel 0", {31'd0, rx_realign}, 0);
  endtask

  task automatic t_tx();
    do_reset(1'b0);
    for (int k = 0; k < 66; k++)
      tx_send(8'(k * 29 + 3), 1'b0, 8, (k % 32) == 0, "R7 R8 tx octet");
  endtask

  task automatic t_txsync();
    do_reset(1'b0);
    for (int k = 0; k < 3; k++) tx_send(8'(k + 1), 1'b0, 8, k == 0, "R9 pre");
    tx_octet = 8'hFF;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_send(8'hB4, 1'b1, 8, 1'b1, "R9 mid-octet restart");
    for (int k = 1; k < 33; k++) tx_send(8'(k * 11), 1'b0, 8, k == 32, "R9 count from restart");
    do_reset(1'b1);
    tx_send(8'h5D, 1'b0, 8, 1'b1, "R6 tx sel 1");
    tx_send(8'hC1, 1'b0, 4, 1'b0, "R6 tx shared pulse ignored");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_send(8'h3A, 1'b1, 8, 1'b1, "R9 link tx pulse");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_prelock();
    t_freerun();
    t_misalign();
    t_select();
    t_tx();
    t_txsync();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule